// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits on the receiving side of a fixed-rate serial control link. A controller sends a 256-bit frame of one 16-bit header slot and twelve 20-bit slots, most significant bit first. The frame starts at a rising edge of a frame strobe. The block turns the header and the first two 20-bit slots into control-register commands. Writes go to a local file of 16-bit registers. For reads, the addressed register is placed on a parallel response port, where an outbound serializer can pick it up for a later frame. The remaining slots carry sample data; the block counts through them and discards them.

The header carries four things: a frame-level valid bit, twelve per-slot valid tags, a spare bit and a two-bit device identity. A command runs only when all of these hold: the frame is valid, the identity matches the strap input, the needed tags are set, and the reserved fields of the command slots are zero. The block samples on the rising edge of `sclk`. The surrounding chip supplies this clock with the phase it needs, for example an inverted bit clock so that data is taken on the falling edge of the bit clock.

Top module: `ac_link_cmd_decoder`

## Requirements
- R1: After reset, `rd_valid`, `rd_index`, `rd_data`, `rsvd_err` and `slot_tags` are zero, and every register reads back as zero.
- R2: The bit sampled when `frame_sync` is first seen high (after being low) is header bit 15. Header bits follow at positions 0..15, command slot bits at 16..35, and data slot bits at 36..55, each MSB first. A read response raises `rd_valid` for exactly one cycle, in the cycle after the edge that samples position 56.
- R3: A frame whose header bit 15 is 0 does not change any register, does not produce a read response, and does not change `rsvd_err`.
- R4: A frame whose header bits 1:0 differ from `strap_id` is ignored in the same way.
- R5: A write (command bit 19 = 0) is applied only when both tag bits are set: header bit 14 (command slot valid) and header bit 13 (data slot valid).
- R6: A read (command bit 19 = 1) needs only header bit 14. It pulses `rd_valid`, sets `rd_index` to command bits 18:12, and sets `rd_data` to that register's contents.
- R7: An index with bit 0 set is reserved. A write to it changes no register, and a read of it responds with `rd_data` = 0.
- R8: All 64 even indices 0x00..0x7E hold independent 16-bit values. Write data is taken from data slot bits 19:4.
- R9: A command is dropped and `rsvd_err` is set to 1 when any of these is nonzero: command bits 11:0, data slot bits 3:0 on a write, or any data slot bit on a read. The next well-formed command that is evaluated clears `rsvd_err` to 0.
- R10: `rd_index` and `rd_data` keep their values until the next accepted read, including across writes to the same register.
- R11: `slot_tags` takes header bits 14:3 (bit 11 = slot 1) at the end of every header whose bit 15 is 1, whatever its identity. Headers with bit 15 = 0 leave it unchanged.
- R12: Nothing is decoded before the first `frame_sync` rising edge. A new rising edge restarts the frame at position 0, and a command cut short this way has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Sampling clock, one edge per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame strobe; its rising edge marks header bit 15 |
| ser_in | input | 1 | Serial frame data, MSB first |
| strap_id | input | 2 | Device identity that commands must match |
| rd_valid | output | 1 | One-cycle pulse for each accepted read |
| rd_index | output | 7 | Index of the last accepted read |
| rd_data | output | 16 | Data of the last accepted read |
| rsvd_err | output | 1 | Last evaluated command had nonzero reserved bits |
| slot_tags | output | 12 | Slot valid tags of the last valid header |

## Verification
An error in the bit position counter or the slot capture moves the read response away from the cycle after position 56, or puts a shifted index on `rd_index`. This shows within the first frame that carries a read. A wrong register-file select or write gate is invisible at the ports until that register is read back. The bench therefore reads every even index after writing it, and reads neighbouring registers after each rejected write. A fault in the gating of identity, tags or reserved bits shows up in the same frame as an unexpected or missing `rd_valid` pulse, or a wrong `rsvd_err`.

// File: rtl/ac_cmd_pkg.sv
package ac_cmd_pkg;

   // header layout: the neighbour that builds frames relies on these positions
   localparam int unsigned TAG_CNT = 12;
   localparam int unsigned CID_W   = 2;
   localparam int unsigned HDR_W   = 1 + TAG_CNT + 1 + CID_W;

   typedef struct packed {
      logic               frame_ok;
      logic [TAG_CNT-1:0] tags;      // tags[TAG_CNT-1] belongs to slot 1
      logic               spare;
      logic [CID_W-1:0]   cid;
   } hdr_t;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_WRITE,
      CMD_READ,
      CMD_FAULT
   } cmd_kind_t;

endpackage

// File: rtl/ac_frame_timer.sv
module ac_frame_timer #(
   parameter int unsigned FRAME_BITS = 256,
   localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   output logic             bit_ok,
   output logic [POS_W-1:0] bit_pos,
   output logic [POS_W-1:0] pos_q
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   logic sync_q;
   logic locked_q;
   logic sync_rise;

   assign sync_rise = sync & ~sync_q;
   assign bit_ok    = sync_rise | locked_q;

   always_comb begin
      if (sync_rise)
         bit_pos = '0;
      else if (pos_q == LAST_POS)
         bit_pos = '0;
      else
         bit_pos = pos_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= 1'b0;
         locked_q <= 1'b0;
         pos_q    <= '0;
      end else begin
         sync_q   <= sync;
         locked_q <= locked_q | sync_rise;
         if (bit_ok)
            pos_q <= bit_pos;
      end
   end

endmodule

// File: rtl/ac_slot_deser.sv
module ac_slot_deser #(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned HDR_W  = 16,
   parameter int unsigned NCAP   = 3,
   parameter int unsigned POS_W  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ser_in,
   input  logic                         bit_ok,
   input  logic [POS_W-1:0]             bit_pos,
   output logic [NCAP-1:0][SLOT_W-1:0]  cap,
   output logic                         hdr_go,
   output logic                         cmd_go
);

   localparam logic [POS_W-1:0] HDR_END = POS_W'(HDR_W - 1);
   localparam logic [POS_W-1:0] CMD_END = POS_W'(HDR_W - 1 + (NCAP - 1) * SLOT_W);

   logic [SLOT_W-2:0] sh_q;
   logic [SLOT_W-1:0] word;

   assign word = {sh_q, ser_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         hdr_go <= 1'b0;
         cmd_go <= 1'b0;
      end else begin
         if (bit_ok)
            sh_q <= word[SLOT_W-2:0];
         hdr_go <= bit_ok && (bit_pos == HDR_END);
         cmd_go <= bit_ok && (bit_pos == CMD_END);
      end
   end

   for (genvar k = 0; k < NCAP; k++) begin : g_cap
      localparam logic [POS_W-1:0] END_POS = POS_W'(HDR_W - 1 + k * SLOT_W);
      logic [SLOT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (bit_ok && (bit_pos == END_POS))
            q <= word;
      end
      assign cap[k] = q;
   end

endmodule

// File: rtl/ac_ctl_regfile.sv
module ac_ctl_regfile #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned REG_CNT = 64,
   localparam int unsigned AW     = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] arr [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && (waddr == AW'(i)))
            q <= wdata;
      end
      assign arr[i] = q;
   end

   assign rdata = arr[raddr];

endmodule

// File: rtl/ac_cmd_exec.sv
module ac_cmd_exec
   import ac_cmd_pkg::*;
#(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 7,
   localparam int unsigned REG_CNT = 2 ** (IDX_W - 1),
   localparam int unsigned PAD1_W  = SLOT_W - 1 - IDX_W,
   localparam int unsigned PAD2_W  = SLOT_W - DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_go,
   input  logic               cmd_go,
   input  hdr_t               hdr,
   input  logic [SLOT_W-1:0]  s1,
   input  logic [SLOT_W-1:0]  s2,
   input  logic [CID_W-1:0]   strap,
   output logic               rd_valid,
   output logic [IDX_W-1:0]   rd_index,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rsvd_err,
   output logic [TAG_CNT-1:0] slot_tags
);

   logic              is_rd;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] wdata;
   logic              s1_pad;
   logic              s2_pad;
   logic              evaluated;
   cmd_kind_t         kind;
   logic              we;
   logic [DATA_W-1:0] rf_rdata;

   assign is_rd  = s1[SLOT_W-1];
   assign idx    = s1[SLOT_W-2 -: IDX_W];
   assign wdata  = s2[SLOT_W-1 -: DATA_W];
   assign s1_pad = |s1[PAD1_W-1:0];
   assign s2_pad = is_rd ? (|s2) : (|s2[PAD2_W-1:0]);

   assign evaluated = cmd_go && hdr.frame_ok && (hdr.cid == strap)
                      && hdr.tags[TAG_CNT-1];

   always_comb begin
      kind = CMD_NONE;
      if (evaluated) begin
         if (s1_pad || s2_pad)
            kind = CMD_FAULT;
         else if (is_rd)
            kind = CMD_READ;
         else if (hdr.tags[TAG_CNT-2])
            kind = CMD_WRITE;
      end
   end

   assign we = (kind == CMD_WRITE) && !idx[0];

   ac_ctl_regfile #(
      .DATA_W  (DATA_W),
      .REG_CNT (REG_CNT)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (idx[IDX_W-1:1]),
      .wdata (wdata),
      .raddr (idx[IDX_W-1:1]),
      .rdata (rf_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_index  <= '0;
         rd_data   <= '0;
         rsvd_err  <= 1'b0;
         slot_tags <= '0;
      end else begin
         rd_valid <= (kind == CMD_READ);
         if (kind == CMD_READ) begin
            rd_index <= idx;
            rd_data  <= idx[0] ? '0 : rf_rdata;
         end
         if (evaluated)
            rsvd_err <= (kind == CMD_FAULT);
         if (hdr_go && hdr.frame_ok)
            slot_tags <= hdr.tags;
      end
   end

endmodule

// File: rtl/ac_link_cmd_decoder.sv
module ac_link_cmd_decoder
   import ac_cmd_pkg::*;
#(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 7,
   localparam int unsigned FRAME_BITS = HDR_W + TAG_CNT * SLOT_W,
   localparam int unsigned POS_W      = $clog2(FRAME_BITS),
   localparam int unsigned NCAP       = 3
) (
   input  logic               sclk,
   input  logic               rst_n,
   input  logic               frame_sync,
   input  logic               ser_in,
   input  logic [CID_W-1:0]   strap_id,
   output logic               rd_valid,
   output logic [IDX_W-1:0]   rd_index,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rsvd_err,
   output logic [TAG_CNT-1:0] slot_tags
);

   if (DATA_W >= SLOT_W) begin : g_chk_data
      $error("DATA_W must leave reserved bits in a slot");
   end
   if (IDX_W + 1 >= SLOT_W || IDX_W < 2) begin : g_chk_idx
      $error("IDX_W out of range for SLOT_W");
   end
   if (HDR_W > SLOT_W) begin : g_chk_hdr
      $error("header must fit a slot-wide shifter");
   end

   logic                        bit_ok;
   logic [POS_W-1:0]            bit_pos;
   logic [POS_W-1:0]            bit_pos_q;
   logic [NCAP-1:0][SLOT_W-1:0] cap;
   logic                        hdr_go;
   logic                        cmd_go;
   hdr_t                        hdr;

   ac_frame_timer #(
      .FRAME_BITS (FRAME_BITS)
   ) u_timer (
      .clk     (sclk),
      .rst_n   (rst_n),
      .sync    (frame_sync),
      .bit_ok  (bit_ok),
      .bit_pos (bit_pos),
      .pos_q   (bit_pos_q)
   );

   ac_slot_deser #(
      .SLOT_W (SLOT_W),
      .HDR_W  (HDR_W),
      .NCAP   (NCAP),
      .POS_W  (POS_W)
   ) u_deser (
      .clk     (sclk),
      .rst_n   (rst_n),
      .ser_in  (ser_in),
      .bit_ok  (bit_ok),
      .bit_pos (bit_pos),
      .cap     (cap),
      .hdr_go  (hdr_go),
      .cmd_go  (cmd_go)
   );

   assign hdr = hdr_t'(cap[0][HDR_W-1:0]);

   ac_cmd_exec #(
      .SLOT_W (SLOT_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_exec (
      .clk       (sclk),
      .rst_n     (rst_n),
      .hdr_go    (hdr_go),
      .cmd_go    (cmd_go),
      .hdr       (hdr),
      .s1        (cap[1]),
      .s2        (cap[2]),
      .strap     (strap_id),
      .rd_valid  (rd_valid),
      .rd_index  (rd_index),
      .rd_data   (rd_data),
      .rsvd_err  (rsvd_err),
      .slot_tags (slot_tags)
   );

endmodule

// File: rtl/ac_link_cmd_decoder_chk.sv
module ac_link_cmd_decoder_chk #(
   parameter int unsigned POS_W    = 8,
   parameter int unsigned IDX_W    = 7,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned EXEC_POS = 56
) (
   input logic              sclk,
   input logic              rst_n,
   input logic              rd_valid,
   input logic [IDX_W-1:0]  rd_index,
   input logic [DATA_W-1:0] rd_data,
   input logic              rsvd_err,
   input logic [POS_W-1:0]  bit_pos_q
);

   AST_RDV_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R2

   AST_RDV_POSITION: assert property (@(posedge sclk) disable iff (!rst_n)
      rd_valid |-> (bit_pos_q == POS_W'(EXEC_POS))); // R2

   AST_ODD_READS_ZERO: assert property (@(posedge sclk) disable iff (!rst_n)
      (rd_valid && rd_index[0]) |-> (rd_data == '0)); // R7

   AST_FAULT_NO_READ: assert property (@(posedge sclk) disable iff (!rst_n)
      rd_valid |-> !rsvd_err); // R9

   AST_DATA_HELD: assert property (@(posedge sclk) disable iff (!rst_n)
      !$stable(rd_data) |-> rd_valid); // R10

   AST_INDEX_HELD: assert property (@(posedge sclk) disable iff (!rst_n)
      !$stable(rd_index) |-> rd_valid); // R10

endmodule

bind ac_link_cmd_decoder ac_link_cmd_decoder_chk u_chk (
   .sclk      (sclk),
   .rst_n     (rst_n),
   .rd_valid  (rd_valid),
   .rd_index  (rd_index),
   .rd_data   (rd_data),
   .rsvd_err  (rsvd_err),
   .bit_pos_q (bit_pos_q)
);

// File: tb/ac_link_cmd_decoder_tb.sv
module ac_link_cmd_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_sync = 1'b0;
   logic        ser_in = 1'b0;
   logic [1:0]  strap_id = 2'b01;
   logic        rd_valid;
   logic [6:0]  rd_index;
   logic [15:0] rd_data;
   logic        rsvd_err;
   logic [11:0] slot_tags;

   int n_chk  = 0;
   int n_fail = 0;
   int rdv_total = 0;
   int last_cnt;
   int last_pos;
   logic [15:0] model [64];

   always #4 clk = ~clk;

   ac_link_cmd_decoder u_dut (
      .sclk       (clk),
      .rst_n      (rst_n),
      .frame_sync (frame_sync),
      .ser_in     (ser_in),
      .strap_id   (strap_id),
      .rd_valid   (rd_valid),
      .rd_index   (rd_index),
      .rd_data    (rd_data),
      .rsvd_err   (rsvd_err),
      .slot_tags  (slot_tags)
   );

   always @(negedge clk) if (rst_n && rd_valid) rdv_total++;

   task automatic report_and_end();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      report_and_end();
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk_hdr(input logic v, input logic t1, input logic t2,
                                          input logic [1:0] id);
      return {v, t1, t2, 10'h155, 1'b0, id};
   endfunction

   function automatic logic [19:0] wr_cmd(input logic [6:0] idx);
      return {1'b0, idx, 12'h000};
   endfunction

   function automatic logic [19:0] rd_cmd(input logic [6:0] idx);
      return {1'b1, idx, 12'h000};
   endfunction

   // drives nbits of a frame; counts read pulses and their position
   task automatic send_bits(input logic [15:0] h, input logic [19:0] s1,
                            input logic [19:0] s2, input int nbits);
      last_cnt = 0;
      last_pos = -1;
      for (int k = 0; k < nbits; k++) begin
         @(negedge clk);
         if (rd_valid) begin
            last_cnt++;
            last_pos = k;
         end
         frame_sync = (k < 16);
         if (k < 16)      ser_in = h[15-k];
         else if (k < 36) ser_in = s1[35-k];
         else if (k < 56) ser_in = s2[55-k];
         else             ser_in = k[0] ^ k[3];
      end
   endtask

   task automatic send_frame(input logic [15:0] h, input logic [19:0] s1, input logic [19:0] s2);
      send_bits(h, s1, s2, 256);
   endtask

   task automatic good_write(input logic [6:0] idx, input logic [15:0] d);
      send_frame(mk_hdr(1, 1, 1, strap_id), wr_cmd(idx), {d, 4'h0});
      if (!idx[0]) model[idx[6:1]] = d;
   endtask

   task automatic read_expect(input string req, input logic [6:0] idx);
      send_frame(mk_hdr(1, 1, 0, strap_id), rd_cmd(idx), 20'h0);
      chk(req, 32'(last_cnt), 32'd1);
      chk(req, 32'(rd_index), 32'(idx));
      chk(req, 32'(rd_data), idx[0] ? 32'd0 : 32'(model[idx[6:1]]));
   endtask

   task automatic t_reset();
      chk("R1 rd_valid", 32'(rd_valid), 0);
      chk("R1 rd_index", 32'(rd_index), 0);
      chk("R1 rd_data", 32'(rd_data), 0);
      chk("R1 rsvd_err", 32'(rsvd_err), 0);
      chk("R1 slot_tags", 32'(slot_tags), 0);
      // R12: serial activity without any strobe edge decodes nothing
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         ser_in = ~ser_in;
      end
      chk("R12 no decode before strobe", 32'(rdv_total), 0);
      read_expect("R1 reset value", 7'h3E);
   endtask

   task automatic t_timing();
      good_write(7'h02, 16'hA5A5);
      send_frame(mk_hdr(1, 1, 0, strap_id), rd_cmd(7'h02), 20'h0);
      chk("R2 single pulse", 32'(last_cnt), 1);
      chk("R2 pulse position", 32'(last_pos), 57);
      chk("R6 index", 32'(rd_index), 32'h02);
      chk("R6 data", 32'(rd_data), 32'hA5A5);
   endtask

   task automatic t_all_regs();
      for (int i = 0; i < 64; i++) good_write(7'(2 * i), 16'(i * 16'h0421 + 16'h1357));
      for (int i = 0; i < 64; i++) read_expect("R8 register file", 7'(2 * i));
   endtask

   task automatic t_invalid_frame();
      send_frame(mk_hdr(0, 1, 1, strap_id), wr_cmd(7'h04), {16'h1111, 4'h0});
      send_frame(mk_hdr(0, 1, 0, strap_id), rd_cmd(7'h04), 20'h0);
      chk("R3 no read on invalid frame", 32'(last_cnt), 0);
      send_frame(mk_hdr(0, 1, 1, strap_id), wr_cmd(7'h04), {16'h1111, 4'h1});
      chk("R3 rsvd_err untouched", 32'(rsvd_err), 0);
      read_expect("R3 register unchanged", 7'h04);
   endtask

   task automatic t_id();
      send_frame(mk_hdr(1, 1, 1, 2'b00), wr_cmd(7'h06), {16'h2222, 4'h0});
      send_frame(mk_hdr(1, 1, 1, 2'b10), wr_cmd(7'h06), {16'h3333, 4'h0});
      send_frame(mk_hdr(1, 1, 0, 2'b11), rd_cmd(7'h06), 20'h0);
      chk("R4 no read on id mismatch", 32'(last_cnt), 0);
      read_expect("R4 register unchanged", 7'h06);
   endtask

   task automatic t_tags_gate();
      send_frame(mk_hdr(1, 1, 0, strap_id), wr_cmd(7'h08), {16'h4444, 4'h0});
      read_expect("R5 write needs data tag", 7'h08);
      send_frame(mk_hdr(1, 0, 1, strap_id), wr_cmd(7'h08), {16'h5555, 4'h0});
      read_expect("R5 write needs command tag", 7'h08);
      send_frame(mk_hdr(1, 0, 1, strap_id), rd_cmd(7'h08), 20'h0);
      chk("R6 read needs command tag", 32'(last_cnt), 0);
      good_write(7'h08, 16'h6789);
      read_expect("R5 write with both tags", 7'h08);
   endtask

   task automatic t_odd();
      good_write(7'h05, 16'hFFFF);
      read_expect("R7 even neighbour below", 7'h04);
      read_expect("R7 even neighbour above", 7'h06);
      read_expect("R7 odd reads zero", 7'h05);
      chk("R7 odd index echoed", 32'(rd_index), 32'h05);
   endtask

   task automatic t_reserved();
      send_frame(mk_hdr(1, 1, 1, strap_id), {1'b0, 7'h0A, 12'h001}, {16'h7777, 4'h0});
      chk("R9 command pad flagged", 32'(rsvd_err), 1);
      read_expect("R9 faulted write dropped", 7'h0A);
      chk("R9 cleared by clean command", 32'(rsvd_err), 0);
      send_frame(mk_hdr(1, 1, 1, strap_id), wr_cmd(7'h0A), {16'h7777, 4'h8});
      chk("R9 data pad flagged", 32'(rsvd_err), 1);
      send_frame(mk_hdr(1, 1, 0, strap_id), rd_cmd(7'h0A), 20'h00100);
      chk("R9 nonzero read data slot flagged", 32'(rsvd_err), 1);
      chk("R9 faulted read no pulse", 32'(last_cnt), 0);
      read_expect("R9 register still unchanged", 7'h0A);
   endtask

   task automatic t_hold();
      read_expect("R10 setup read", 7'h0C);
      good_write(7'h0C, 16'hBEEF);
      chk("R10 data held across write", 32'(rd_data), 32'(16'(6 * 16'h0421 + 16'h1357)));
      chk("R10 index held across write", 32'(rd_index), 32'h0C);
      read_expect("R10 fresh read", 7'h0C);
   endtask

   task automatic t_slot_tags();
      send_frame({1'b1, 12'hA5C, 1'b0, 2'b10}, 20'h0, 20'h0);
      chk("R11 tags from valid header", 32'(slot_tags), 32'hA5C);
      send_frame({1'b0, 12'h3C3, 1'b0, strap_id}, 20'h0, 20'h0);
      chk("R11 tags kept on invalid header", 32'(slot_tags), 32'hA5C);
   endtask

   task automatic t_resync();
      send_bits(mk_hdr(1, 1, 1, strap_id), wr_cmd(7'h10), {16'hDEAD, 4'h0}, 40);
      read_expect("R12 cut command has no effect", 7'h10);
      chk("R12 realigned pulse position", 32'(last_pos), 57);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timing();
      t_all_regs();
      t_invalid_frame();
      t_id();
      t_tags_gate();
      t_odd();
      t_reserved();
      t_hold();
      t_slot_tags();
      t_resync();
      report_and_end();
   end

endmodule